// File: doc/BRIEF.md
# Monochrome Hardware Cursor Overlay

This block draws a 64x64 two-plane monochrome cursor over a stream of 32-bit pixels, one scanline at a time. At the start of each scanline, while horizontal blanking is running, the timing logic pulses `line_req` with the screen line number. If that line crosses the cursor, the block reads the 16 bytes of that cursor row through a byte-read port into a small line buffer. Pixels then flow through a valid/ready stream. Each pixel is passed on unchanged, inverted, or replaced by one of two cursor colours.

Each cursor row takes 16 bytes, starting at the cursor offset plus 16 times the row number. The first eight bytes form the AND plane. The next eight form the XOR plane. Within a plane, byte i covers pixels i*8 to i*8+7, most significant bit first. The position register holds X in bits 31:16 and Y in bits 15:0. Bit 31 of the offset register is a lock. At each line start the block copies the offset and position into its working copy, but only while the lock is clear.

Stream rules: `m_valid` equals `s_valid`, and `m_pixel` is combinational from `s_pixel`. `s_ready` equals `m_ready` except while a row fetch is in progress, when it is held low. A pixel is consumed, and the pixel column advances, only on a cycle with `s_valid` and `s_ready` both high. `line_req` is only honoured while no fetch is in progress. It resets the pixel column to 0.

Top module: `hw_cursor_overlay`

## Requirements
- R1: After reset, `mem_rd` is low, `s_ready` follows `m_ready`, and pixels pass through unchanged.
- R2: `m_valid` equals `s_valid` and `s_ready` equals `m_ready` outside a fetch. While `m_ready` is low, no pixel is consumed and the pixel column does not advance.
- R3: A `line_req` for a line inside the cursor window issues 16 byte reads, one per cycle, at consecutive addresses starting at offset + (line_y - cursor_y) * 16. Read data is taken one cycle after its read. `s_ready` is low for the 17 cycles after the `line_req` edge.
- R4: Bytes 0 to 7 of a row form the AND plane and bytes 8 to 15 the XOR plane. Cursor column c uses bit 7-(c mod 8) of byte c/8 in each plane.
- R5: AND=1 and XOR=1 outputs the bitwise complement of all 32 bits of the input pixel.
- R6: AND=1 and XOR=0 outputs the input pixel unchanged.
- R7: AND=0 outputs {8'hFF, color1} when XOR=1 and {8'hFF, color0} when XOR=0.
- R8: A pixel at column x is drawn only if cursor_x <= x < cursor_x + 64 and x < `h_width`. Other pixels pass unchanged, and the cursor never wraps to the next line.
- R9: A line is drawn only if cursor_y <= line_y < cursor_y + 64 and line_y <= `v_last`. For any other line no read is issued and all pixels pass unchanged.
- R10: With `cfg_enable` low at `line_req`, no read is issued and the line passes unchanged.
- R11: With `cfg_offset` bit 31 set at `line_req`, the previously applied offset and position stay in use.
- R12: X is taken from `cfg_pos[31:16]` and Y from `cfg_pos[15:0]`. The offset is `cfg_offset[30:0]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| line_req | input | 1 | Start-of-line pulse, given during blanking |
| line_y | input | 16 | Screen line about to be shown |
| v_last | input | 16 | Last displayed line |
| h_width | input | 16 | Displayed pixels per line |
| cfg_enable | input | 1 | Cursor enable |
| cfg_offset | input | 32 | Bit 31 lock, bits 30:0 cursor memory offset |
| cfg_pos | input | 32 | X in 31:16, Y in 15:0 |
| color0 | input | 24 | Colour for AND=0, XOR=0 |
| color1 | input | 24 | Colour for AND=0, XOR=1 |
| s_valid | input | 1 | Input pixel valid |
| s_ready | output | 1 | Input pixel accepted |
| s_pixel | input | 32 | Input pixel |
| m_valid | output | 1 | Output pixel valid |
| m_ready | input | 1 | Downstream ready |
| m_pixel | output | 32 | Output pixel |
| mem_rd | output | 1 | Byte read strobe |
| mem_addr | output | 31 | Byte read address |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |

## Verification
The bench models memory with an arithmetic byte function, so every cursor row mixes all four AND/XOR codes. Each line compares every pixel, including pixels past the display width, against a model computed in the bench.

The lines cover these cases:
- the first and last cursor rows, which tell the address stride apart from an off-by-one;
- the rows just above and below the cursor;
- a cursor straddling the right edge, which separates clipping from wrapping;
- lines on either side of the last display line;
- a disabled cursor;
- a locked register update, whose new values must not appear;
- a line with a stalled output, which shows whether the column counter advances on refused pixels.

Read counts, address continuity and stall length are checked on every line.

// File: rtl/hw_cursor_pkg.sv
package hw_cursor_pkg;
  localparam int PIX_W   = 32;
  localparam int COLOR_W = 24;

  typedef enum logic [1:0] {
    ACT_PASS   = 2'd0,
    ACT_INVERT = 2'd1,
    ACT_COLOR0 = 2'd2,
    ACT_COLOR1 = 2'd3
  } cur_action_e;

  function automatic cur_action_e pick_action(input logic hit, input logic and_b,
                                              input logic xor_b);
    if (!hit)        return ACT_PASS;
    else if (and_b)  return xor_b ? ACT_INVERT : ACT_PASS;
    else             return xor_b ? ACT_COLOR1 : ACT_COLOR0;
  endfunction
endpackage

// File: rtl/cursor_line_fetch.sv
module cursor_line_fetch #(
  parameter int ADDR_W  = 31,
  parameter int XY_W    = 16,
  parameter int CUR_DIM = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_req,
  input  logic [XY_W-1:0]     line_y,
  input  logic [XY_W-1:0]     v_last,
  input  logic                cfg_enable,
  input  logic [ADDR_W:0]     cfg_offset,
  input  logic [2*XY_W-1:0]   cfg_pos,
  output logic                busy,
  output logic                line_hit,
  output logic [XY_W-1:0]     cur_x,
  output logic [CUR_DIM-1:0]  and_plane,
  output logic [CUR_DIM-1:0]  xor_plane,
  output logic                mem_rd,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic [7:0]          mem_rdata
);
  localparam int PLANE_BYTES = CUR_DIM / 8;
  localparam int LINE_BYTES  = 2 * PLANE_BYTES;
  localparam int CNT_W       = $clog2(LINE_BYTES + 1);

  logic [ADDR_W-1:0] app_off, nxt_off, base_q;
  logic [XY_W-1:0]   app_x, app_y, nxt_x, nxt_y, row;
  logic              lock, in_win;
  logic [CNT_W-1:0]  cnt, idx;

  always_comb begin
    lock    = cfg_offset[ADDR_W];
    nxt_off = lock ? app_off : cfg_offset[ADDR_W-1:0];
    nxt_x   = lock ? app_x : cfg_pos[2*XY_W-1:XY_W];
    nxt_y   = lock ? app_y : cfg_pos[XY_W-1:0];
    row     = line_y - nxt_y;
    in_win  = cfg_enable && (line_y >= nxt_y) && (line_y <= v_last) &&
              ({1'b0, line_y} < ({1'b0, nxt_y} + (XY_W+1)'(CUR_DIM)));
    idx     = cnt - CNT_W'(1);
  end

  assign mem_rd   = busy && (cnt < CNT_W'(LINE_BYTES));
  assign mem_addr = base_q + ADDR_W'(cnt);
  assign cur_x    = app_x;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      app_off   <= '0;
      app_x     <= '0;
      app_y     <= '0;
      base_q    <= '0;
      busy      <= 1'b0;
      line_hit  <= 1'b0;
      cnt       <= '0;
      and_plane <= '0;
      xor_plane <= '0;
    end else begin
      if (line_req && !busy) begin
        app_off  <= nxt_off;
        app_x    <= nxt_x;
        app_y    <= nxt_y;
        line_hit <= in_win;
        base_q   <= nxt_off + ADDR_W'(row) * ADDR_W'(LINE_BYTES);
        if (in_win) begin
          busy <= 1'b1;
          cnt  <= '0;
        end
      end else if (busy) begin
        cnt <= cnt + CNT_W'(1);
        if (cnt == CNT_W'(LINE_BYTES)) busy <= 1'b0;
      end
      if (busy && cnt != '0) begin
        for (int i = 0; i < PLANE_BYTES; i++) begin
          if (idx == CNT_W'(i))
            for (int j = 0; j < 8; j++) and_plane[i*8+j] <= mem_rdata[7-j];
          if (idx == CNT_W'(i + PLANE_BYTES))
            for (int j = 0; j < 8; j++) xor_plane[i*8+j] <= mem_rdata[7-j];
        end
      end
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |-> mem_addr == $past(mem_addr) + ADDR_W'(1)); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    line_req && !busy && cfg_offset[ADDR_W] |=> app_x == $past(app_x) && app_off == $past(app_off)); // R11
  AST_NO_READ_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    line_req && !busy && !in_win |=> !mem_rd); // R9
endmodule

// File: rtl/cursor_pixel_mix.sv
module cursor_pixel_mix
  import hw_cursor_pkg::*;
#(
  parameter int XY_W    = 16,
  parameter int CUR_DIM = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_req,
  input  logic               pix_take,
  input  logic [PIX_W-1:0]   s_pixel,
  input  logic               line_hit,
  input  logic [XY_W-1:0]    cur_x,
  input  logic [XY_W-1:0]    h_width,
  input  logic [CUR_DIM-1:0] and_plane,
  input  logic [CUR_DIM-1:0] xor_plane,
  input  logic [COLOR_W-1:0] color0,
  input  logic [COLOR_W-1:0] color1,
  output logic [PIX_W-1:0]   m_pixel
);
  localparam int COL_W = $clog2(CUR_DIM);

  logic [XY_W-1:0]  px;
  logic [COL_W-1:0] col;
  logic             hit;
  cur_action_e      act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        px <= '0;
    else if (line_req) px <= '0;
    else if (pix_take) px <= px + XY_W'(1);
  end

  always_comb begin
    col = COL_W'(px - cur_x);
    hit = line_hit && (px >= cur_x) && (px < h_width) &&
          ({1'b0, px} < ({1'b0, cur_x} + (XY_W+1)'(CUR_DIM)));
    act = pick_action(hit, and_plane[col], xor_plane[col]);
    case (act)
      ACT_INVERT: m_pixel = ~s_pixel;
      ACT_COLOR0: m_pixel = {{(PIX_W-COLOR_W){1'b1}}, color0};
      ACT_COLOR1: m_pixel = {{(PIX_W-COLOR_W){1'b1}}, color1};
      default:    m_pixel = s_pixel;
    endcase
  end

  AST_CLIP_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    px >= h_width |-> m_pixel == s_pixel); // R8
  AST_ALPHA_SET: assert property (@(posedge clk) disable iff (!rst_n)
    hit && !and_plane[col] |-> m_pixel[PIX_W-1:COLOR_W] == '1); // R7
endmodule

// File: rtl/hw_cursor_overlay.sv
module hw_cursor_overlay
  import hw_cursor_pkg::*;
#(
  parameter int ADDR_W  = 31,
  parameter int XY_W    = 16,
  parameter int CUR_DIM = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_req,
  input  logic [XY_W-1:0]    line_y,
  input  logic [XY_W-1:0]    v_last,
  input  logic [XY_W-1:0]    h_width,
  input  logic               cfg_enable,
  input  logic [ADDR_W:0]    cfg_offset,
  input  logic [2*XY_W-1:0]  cfg_pos,
  input  logic [COLOR_W-1:0] color0,
  input  logic [COLOR_W-1:0] color1,
  input  logic               s_valid,
  output logic               s_ready,
  input  logic [PIX_W-1:0]   s_pixel,
  output logic               m_valid,
  input  logic               m_ready,
  output logic [PIX_W-1:0]   m_pixel,
  output logic               mem_rd,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic [7:0]         mem_rdata
);
  logic               busy, line_hit;
  logic [XY_W-1:0]    cur_x;
  logic [CUR_DIM-1:0] and_plane, xor_plane;

  assign s_ready = m_ready && !busy;
  assign m_valid = s_valid;

  cursor_line_fetch #(.ADDR_W(ADDR_W), .XY_W(XY_W), .CUR_DIM(CUR_DIM)) u_fetch (
    .clk, .rst_n, .line_req, .line_y, .v_last, .cfg_enable, .cfg_offset, .cfg_pos,
    .busy, .line_hit, .cur_x, .and_plane, .xor_plane, .mem_rd, .mem_addr, .mem_rdata
  );

  cursor_pixel_mix #(.XY_W(XY_W), .CUR_DIM(CUR_DIM)) u_mix (
    .clk, .rst_n, .line_req, .pix_take(s_valid && s_ready), .s_pixel, .line_hit,
    .cur_x, .h_width, .and_plane, .xor_plane, .color0, .color1, .m_pixel
  );

  AST_NO_TAKE_DURING_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !s_ready); // R3
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !m_ready |-> !s_ready); // R2
endmodule

// File: tb/hw_cursor_overlay_bench.sv
`timescale 1ns/1ps
module hw_cursor_overlay_bench;
  localparam int HW = 200;
  localparam int VL = 100;

  logic clk = 0, rst_n = 0;
  logic line_req = 0, cfg_enable = 0, s_valid = 0, m_ready = 1;
  logic [15:0] line_y = 0, v_last = VL, h_width = HW;
  logic [31:0] cfg_offset = 0, cfg_pos = 0, s_pixel = 0;
  logic [23:0] color0 = 24'h00C0FF, color1 = 24'h3355AA;
  logic s_ready, m_valid, mem_rd;
  logic [31:0] m_pixel;
  logic [30:0] mem_addr;
  logic [7:0] mem_rdata = 0;

  int errors = 0, checks = 0;
  int rdcount = 0, contig_bad = 0;
  logic [30:0] first_addr = 0, last_addr = 0;
  int moff = 0, mx = 0, my = 0;
  bit men = 0;

  always #2 clk = ~clk;

  hw_cursor_overlay u_hw_cursor_overlay (
    .clk, .rst_n, .line_req, .line_y, .v_last, .h_width, .cfg_enable, .cfg_offset,
    .cfg_pos, .color0, .color1, .s_valid, .s_ready, .s_pixel, .m_valid, .m_ready,
    .m_pixel, .mem_rd, .mem_addr, .mem_rdata
  );

  function automatic logic [7:0] memf(input int a);
    int t;
    t = (a * 29) ^ (a >> 3) ^ 32'h5A;
    return t[7:0];
  endfunction

  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= memf(int'(mem_addr));
      if (rdcount == 0) first_addr = mem_addr;
      else if (mem_addr != last_addr + 31'd1) contig_bad = 1;
      last_addr = mem_addr;
      rdcount = rdcount + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pixf(input int x, input int y);
    return (x * 32'h01030507) ^ (y << 20) ^ 32'h12345678;
  endfunction

  task automatic do_line(input int y, input string ltag, input bit stall);
    bit active;
    int stalls;
    @(negedge clk);
    line_y = y[15:0];
    line_req = 1;
    rdcount = 0;
    contig_bad = 0;
    if (!cfg_offset[31]) begin
      moff = int'(cfg_offset[30:0]);
      mx = int'(cfg_pos[31:16]);
      my = int'(cfg_pos[15:0]);
    end
    men = cfg_enable;
    active = men && y >= my && y < my + 64 && y <= VL;
    @(negedge clk);
    line_req = 0;
    stalls = 0;
    while (!s_ready && stalls < 40) begin
      stalls++;
      @(negedge clk);
    end
    check({"R3 stall cycles ", ltag}, stalls, active ? 17 : 0);
    check({"R3 R9 R10 read count ", ltag}, rdcount, active ? 16 : 0);
    if (active) begin
      check({"R3 R12 first address ", ltag}, first_addr, moff + (y - my) * 16);
      check({"R3 contiguous ", ltag}, contig_bad, 0);
    end
    for (int x = 0; x < HW + 8; x++) begin
      logic [31:0] p, e;
      string t;
      if (stall && x == 3) begin
        m_ready = 0;
        s_valid = 1;
        s_pixel = 32'hDEAD0000;
        for (int k = 0; k < 2; k++) begin
          #1;
          check("R2 s_ready low while stalled", s_ready, 0);
          check("R2 m_valid follows s_valid", m_valid, 1);
          @(negedge clk);
        end
        m_ready = 1;
      end
      p = pixf(x, y);
      s_valid = 1;
      s_pixel = p;
      e = p;
      t = {"R8 R9 pass ", ltag};
      if (!men) t = {"R10 disabled ", ltag};
      if (active && x >= mx && x < mx + 64 && x < HW) begin
        int c;
        logic [7:0] ab, xb;
        logic a, xo;
        c = x - mx;
        ab = memf(moff + (y - my) * 16 + c / 8);
        xb = memf(moff + (y - my) * 16 + 8 + c / 8);
        a = ab[7 - c % 8];
        xo = xb[7 - c % 8];
        if (a && xo)      begin e = ~p; t = {"R4 R5 invert ", ltag}; end
        else if (a)       begin e = p; t = {"R4 R6 transparent ", ltag}; end
        else if (xo)      begin e = {8'hFF, color1}; t = {"R4 R7 colour1 ", ltag}; end
        else              begin e = {8'hFF, color0}; t = {"R4 R7 colour0 ", ltag}; end
      end
      #1;
      check(t, m_pixel, e);
      @(negedge clk);
    end
    s_valid = 0;
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    s_valid = 1;
    s_pixel = 32'hA5A5_0F0F;
    #1;
    check("R1 no read after reset", mem_rd, 0);
    check("R1 s_ready follows m_ready", s_ready, 1);
    check("R1 pass through after reset", m_pixel, 32'hA5A5_0F0F);
    check("R2 m_valid equals s_valid", m_valid, 1);
    s_valid = 0;

    cfg_enable = 1;
    cfg_offset = 32'h0000_1000;
    cfg_pos = (32'd10 << 16) | 32'd20;
    do_line(20, "first row", 0);
    do_line(83, "last row", 0);
    do_line(84, "below cursor", 0);
    do_line(19, "above cursor", 0);

    cfg_pos = (32'd170 << 16) | 32'd50;
    do_line(60, "right edge", 0);

    cfg_pos = (32'd40 << 16) | 32'd90;
    do_line(100, "last display line", 0);
    do_line(101, "past display end", 0);

    cfg_enable = 0;
    do_line(95, "disabled", 0);
    cfg_enable = 1;

    cfg_offset = 32'h8000_2340;
    cfg_pos = 32'd0;
    do_line(95, "R11 locked", 0);

    cfg_offset = 32'h0000_2340;
    do_line(5, "R12 unlocked origin", 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule